// File: doc/BRIEF.md
# Iterative Integer Divider with Truncating and Flooring Rounding

This block divides one W-bit integer by another and returns a W-bit quotient and a W-bit remainder. Each operand has its own signedness flag. A one-bit mode input picks the rounding convention.

- **Truncating mode** rounds the quotient toward zero. The remainder carries the sign of the dividend.
- **Flooring mode** rounds the quotient toward negative infinity. The remainder is adjusted so that quotient times divisor plus remainder still equals the dividend.

The datapath works on operand magnitudes. A restoring shift-subtract loop produces one quotient bit per cycle. Combinational logic then applies the signs and, where needed, a floor correction before the result is registered.

To use the block, hold the operands, flags and mode on the inputs and pulse `start_i` for one cycle while the divider is idle. Exactly W cycles later, `done_o` pulses for one cycle. At that point `quot_o` and `rem_o` hold the result, and they keep it until the next completion. A zero divisor is reported on `div_zero_o`, which pulses together with `done_o`.

Top module: `rnd_divider`

## Requirements
- R1: After reset, `done_o` and `div_zero_o` are 0, and `quot_o` and `rem_o` are all zeros.
- R2: A start accepted at clock edge E makes `done_o` high for exactly one cycle, following edge E+W. Here W is the operand width (default 8).
- R3: A start is accepted only while no division is in flight; operands, flags and mode are captured at acceptance. A `start_i` pulse during a running division is ignored. That running division still completes on time with its own operands.
- R4: With both signedness flags 0, the operands are unsigned. The quotient is floor(a/b) and the remainder is a mod b, in either mode.
- R5: A signedness flag of 1 marks that operand as two's complement. With `mode_i`=0 (truncating), the quotient rounds toward zero. The remainder magnitude is |a| mod |b|, with the sign of the dividend.
- R6: With `mode_i`=1 (flooring), both flags 1, operand signs different and a nonzero remainder, the quotient is the truncated quotient minus 1. The remainder is the truncated remainder plus the divisor.
- R7: With `mode_i`=1 and both flags 1, if the operand signs agree or the remainder is zero, the result equals the truncating result.
- R8: With `mode_i`=1 and either flag 0, the result equals the truncating result for the same operands and flags.
- R9: A zero divisor raises `div_zero_o` together with `done_o`, and forces `quot_o` and `rem_o` to all ones. With a nonzero divisor, `div_zero_o` stays 0.
- R10: Results wrap to W bits. The most negative signed dividend divided by signed −1 yields the bit pattern 1 followed by W−1 zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division (taken only when idle) |
| mode_i | input | 1 | 0 truncating, 1 flooring |
| a_signed_i | input | 1 | Dividend is two's complement |
| b_signed_i | input | 1 | Divisor is two's complement |
| dividend_i | input | W | Dividend |
| divisor_i | input | W | Divisor |
| quot_o | output | W | Quotient, held after completion |
| rem_o | output | W | Remainder, held after completion |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divide-by-zero flag, pulses with `done_o` |

## Verification
The assertions assume that W is at least 2, so a completion pulse can never be followed at once by another. They also assume that `start_i` is a clean level sampled at the clock: any value during a division must leave the captured divisor and sign state untouched. The bench drives every input at the falling edge and keeps the operands steady until acceptance. It holds `start_i` for a single cycle, except for one deliberate pulse in the middle of a division. It samples outputs only at falling edges.

// File: rtl/rnd_div_pkg.sv
package rnd_div_pkg;
  typedef enum logic {
    RND_TRUNC = 1'b0,
    RND_FLOOR = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/div_mag.sv
module div_mag #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         is_signed_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  always_comb begin
    neg_o = is_signed_i & val_i[W-1];
    mag_o = neg_o ? (~val_i + W'(1)) : val_i;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] q_nxt_o,
  output logic [W-1:0] r_nxt_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_q, d_q;
  logic [W:0]    r_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, diff, r_nxt;
  logic          take;

  always_comb begin
    shifted = {r_q[W-1:0], q_q[W-1]};
    diff    = shifted - {1'b0, d_q};
    take    = ~diff[W];
    r_nxt   = take ? diff : shifted;
  end

  assign busy_o  = (cnt_q != '0);
  assign last_o  = (cnt_q == CW'(1));
  assign q_nxt_o = {q_q[W-2:0], take};
  assign r_nxt_o = r_nxt[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      d_q   <= '0;
      r_q   <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      q_q   <= dvd_i;
      d_q   <= dvs_i;
      r_q   <= '0;
      cnt_q <= CW'(W);
    end else if (busy_o) begin
      q_q   <= q_nxt_o;
      r_q   <= r_nxt;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // restoring invariant: partial remainder stays below the divisor
  p_rem_below_divisor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && d_q != '0) |-> (r_q < {1'b0, d_q}));
endmodule

// File: rtl/div_fixup.sv
module div_fixup
  import rnd_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] uq_i,
  input  logic [W-1:0] ur_i,
  input  logic         neg_a_i,
  input  logic         neg_b_i,
  input  logic         both_signed_i,
  input  rnd_mode_e    mode_i,
  input  logic [W-1:0] divisor_i,
  input  logic         dz_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o
);
  logic [W-1:0] trunc_q, trunc_r;
  logic         adjust;

  always_comb begin
    trunc_q = (neg_a_i ^ neg_b_i) ? (W'(0) - uq_i) : uq_i;
    trunc_r = neg_a_i ? (W'(0) - ur_i) : ur_i;
    adjust  = (mode_i == RND_FLOOR) && both_signed_i && (neg_a_i ^ neg_b_i) && (ur_i != '0);
    if (dz_i) begin
      q_o = '1;
      r_o = '1;
    end else if (adjust) begin
      q_o = W'(0) - (uq_i + W'(1));
      r_o = trunc_r + divisor_i;
    end else begin
      q_o = trunc_q;
      r_o = trunc_r;
    end
  end
endmodule

// File: rtl/rnd_divider.sv
module rnd_divider
  import rnd_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic         a_signed_i,
  input  logic         b_signed_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o,
  output logic         done_o,
  output logic         div_zero_o
);
  logic         busy, last, accept;
  logic         neg_a, neg_b;
  logic [W-1:0] mag_a, mag_b;
  logic [W-1:0] uq, ur, fix_q, fix_r;

  logic         neg_a_q, neg_b_q, both_q, dz_q;
  rnd_mode_e    mode_q;
  logic [W-1:0] b_q;

  assign accept = start_i & ~busy;

  div_mag #(.W(W)) u_mag_a (.val_i(dividend_i), .is_signed_i(a_signed_i), .neg_o(neg_a), .mag_o(mag_a));
  div_mag #(.W(W)) u_mag_b (.val_i(divisor_i),  .is_signed_i(b_signed_i), .neg_o(neg_b), .mag_o(mag_b));

  div_core #(.W(W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .dvd_i(mag_a), .dvs_i(mag_b),
    .busy_o(busy), .last_o(last), .q_nxt_o(uq), .r_nxt_o(ur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      both_q  <= 1'b0;
      dz_q    <= 1'b0;
      mode_q  <= RND_TRUNC;
      b_q     <= '0;
    end else if (accept) begin
      neg_a_q <= neg_a;
      neg_b_q <= neg_b;
      both_q  <= a_signed_i & b_signed_i;
      dz_q    <= (divisor_i == '0);
      mode_q  <= rnd_mode_e'(mode_i);
      b_q     <= divisor_i;
    end
  end

  div_fixup #(.W(W)) u_fix (
    .uq_i(uq), .ur_i(ur), .neg_a_i(neg_a_q), .neg_b_i(neg_b_q),
    .both_signed_i(both_q), .mode_i(mode_q), .divisor_i(b_q), .dz_i(dz_q),
    .q_o(fix_q), .r_o(fix_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o     <= 1'b0;
      div_zero_o <= 1'b0;
      quot_o     <= '0;
      rem_o      <= '0;
    end else begin
      done_o     <= last;
      div_zero_o <= last & dz_q;
      if (last) begin
        quot_o <= fix_q;
        rem_o  <= fix_r;
      end
    end
  end

  p_done_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_dz_with_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> done_o);

  p_dz_all_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_zero_o) |-> ((&quot_o) && (&rem_o)));

  p_busy_keeps_operands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last && start_i) |=> ($stable(b_q) && $stable(neg_a_q) && $stable(mode_q)));
endmodule

// File: tb/rnd_divider_tb.sv
module rnd_divider_tb;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, mode = 1'b0, sa = 1'b0, sb = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] quot, rem;
  logic         done, dz;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rnd_divider #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .a_signed_i(sa), .b_signed_i(sb), .dividend_i(a), .divisor_i(b),
    .quot_o(quot), .rem_o(rem), .done_o(done), .div_zero_o(dz)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected results derived from the requirements
  task automatic ref_div(input logic [W-1:0] av_i, input logic [W-1:0] bv_i,
                         input logic s_a, input logic s_b, input logic md,
                         output logic [W-1:0] eq, output logic [W-1:0] er, output logic edz);
    longint x, y, q, r;
    x = s_a ? longint'($signed(av_i)) : longint'(av_i);
    y = s_b ? longint'($signed(bv_i)) : longint'(bv_i);
    if (y == 0) begin
      eq = '1; er = '1; edz = 1'b1;
    end else begin
      q = x / y;
      r = x % y;
      if (md && s_a && s_b && r != 0 && ((x < 0) != (y < 0))) begin
        q = q - 1;
        r = r + y;
      end
      eq = W'(q); er = W'(r); edz = 1'b0;
    end
  endtask

  task automatic launch(input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic s_a, input logic s_b, input logic md);
    @(negedge clk);
    a = av; b = bv; sa = s_a; sb = s_b; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // wait from the negedge after acceptance; returns cycles to done
  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 4*W) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_op(input string req, input logic [W-1:0] av, input logic [W-1:0] bv,
                        input logic s_a, input logic s_b, input logic md);
    logic [W-1:0] eq, er;
    logic edz;
    int lat;
    ref_div(av, bv, s_a, s_b, md, eq, er, edz);
    launch(av, bv, s_a, s_b, md);
    wait_done(lat);
    chk({req, " latency"}, lat, W);
    chk({req, " quotient"}, quot, eq);
    chk({req, " remainder"}, rem, er);
    chk({req, " div_zero"}, dz, edz);
  endtask

  task automatic t_reset_r1;
    chk("R1 done", done, 0);
    chk("R1 div_zero", dz, 0);
    chk("R1 quot", quot, 0);
    chk("R1 rem", rem, 0);
  endtask

  task automatic t_timing_r2;
    int lat;
    launch(8'd100, 8'd7, 1'b0, 1'b0, 1'b0);
    wait_done(lat);
    chk("R2 latency", lat, W);
    @(negedge clk);
    chk("R2 single pulse", done, 0);
    chk("R2 result held", quot, 14);
  endtask

  task automatic t_busy_r3;
    logic [W-1:0] eq, er;
    logic edz;
    int lat;
    ref_div(8'd200, 8'd9, 1'b0, 1'b0, 1'b0, eq, er, edz);
    launch(8'd200, 8'd9, 1'b0, 1'b0, 1'b0);
    lat = 0;
    repeat (3) begin @(negedge clk); lat++; end
    a = 8'hF9; b = 8'h00; sa = 1'b1; sb = 1'b1; mode = 1'b1; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 4*W) begin @(negedge clk); lat++; end
    chk("R3 latency unchanged", lat, W);
    chk("R3 quotient of first op", quot, eq);
    chk("R3 remainder of first op", rem, er);
    chk("R3 no div_zero from ignored start", dz, edz);
    repeat (2) @(negedge clk);
    chk("R3 no second completion", done, 0);
  endtask

  task automatic t_unsigned_r4;
    run_op("R4 200/9 trunc", 8'd200, 8'd9, 0, 0, 0);
    run_op("R4 255/16 floor", 8'd255, 8'd16, 0, 0, 1);
    run_op("R4 5/200", 8'd5, 8'd200, 0, 0, 0);
  endtask

  task automatic t_trunc_r5;
    run_op("R5 -7/2", 8'hF9, 8'd2, 1, 1, 0);
    run_op("R5 7/-2", 8'd7, 8'hFE, 1, 1, 0);
    run_op("R5 -7/-2", 8'hF9, 8'hFE, 1, 1, 0);
    run_op("R5 -100/7", 8'h9C, 8'd7, 1, 1, 0);
  endtask

  task automatic t_floor_r6;
    run_op("R6 -7/2", 8'hF9, 8'd2, 1, 1, 1);
    run_op("R6 7/-2", 8'd7, 8'hFE, 1, 1, 1);
    run_op("R6 -1/127", 8'hFF, 8'd127, 1, 1, 1);
    run_op("R6 100/-3", 8'd100, 8'hFD, 1, 1, 1);
  endtask

  task automatic t_floor_same_r7;
    run_op("R7 -7/-2", 8'hF9, 8'hFE, 1, 1, 1);
    run_op("R7 -8/2", 8'hF8, 8'd2, 1, 1, 1);
    run_op("R7 0/-5", 8'd0, 8'hFB, 1, 1, 1);
  endtask

  task automatic t_floor_mixed_r8;
    run_op("R8 -7 signed/200 unsigned", 8'hF9, 8'd200, 1, 0, 1);
    run_op("R8 249 unsigned/-2 signed", 8'hF9, 8'hFE, 0, 1, 1);
  endtask

  task automatic t_divzero_r9;
    run_op("R9 signed /0", 8'hF9, 8'd0, 1, 1, 1);
    run_op("R9 unsigned /0", 8'd42, 8'd0, 0, 0, 0);
    run_op("R9 after zero, normal", 8'd42, 8'd5, 0, 0, 0);
  endtask

  task automatic t_wrap_r10;
    run_op("R10 -128/-1 trunc", 8'h80, 8'hFF, 1, 1, 0);
    run_op("R10 -128/-1 floor", 8'h80, 8'hFF, 1, 1, 1);
    run_op("R10 -128/1", 8'h80, 8'd1, 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_timing_r2();
    t_busy_r3();
    t_unsigned_r4();
    t_trunc_r5();
    t_floor_r6();
    t_floor_same_r7();
    t_floor_mixed_r8();
    t_divzero_r9();
    t_wrap_r10();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule